// File: doc/BRIEF.md
# Memory Row Boundary Decoder

The block turns a physical address into a chip-select row of a memory with several rows. Each row has an 8-bit boundary register that holds the cumulative upper limit of that row in 16 MB units, so the limit in bytes is the register value multiplied by 2^24. A row starts where the previous non-empty row ends, and row 0 starts at address zero. A row whose limit does not rise above the highest limit below it is empty and is never selected.

Software loads the boundary registers through a byte-wide write port with a row index. The address side takes a valid-qualified address. One clock later the block presents a one-hot row select, a hit or miss flag, and the offset of the address from the start of the selected row.

Top module: `rbd_row_decoder`

## Requirements
- R1: After reset every boundary register is zero, `dec_valid`, `row_sel`, `row_hit`, `row_miss` and `row_offset` are zero, and every address presented then misses.
- R2: A cycle with `cfg_we` high loads `cfg_data` into boundary register `cfg_idx`. An address presented in the same cycle is decoded with the old value. Addresses presented in later cycles use the new value.
- R3: Row 0 covers addresses from 0 up to, but not including, its register value times 2^24.
- R4: Row n (n > 0) covers addresses from its base up to, but not including, its own limit. The base is the highest limit of rows 0..n-1. An address equal to a limit belongs to the next non-empty row.
- R5: A row whose limit equals its base is empty and is never selected. Its base passes unchanged to the next row.
- R6: A row whose limit is below its base is empty. It never produces a select that overlaps another row. The base of the next row stays at the highest lower limit.
- R7: An address at or above the highest of the four limits gives `row_miss`=1, `row_hit`=0 and `row_sel`=0.
- R8: `row_offset` is the address minus the base of the selected row. On a miss it is 0.
- R9: `dec_valid` equals `addr_valid` of the previous cycle. When `addr_valid` is low, `row_sel`, `row_hit`, `row_miss` and `row_offset` keep their values.
- R10: Bit n of `row_sel` stands for row n. At most one bit is set, and `row_hit` is 1 exactly when one bit is set.
- R11: Register values of 0x80 and above give limits of 2^31 and beyond. Such a row covers every 31-bit address above its base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_idx | input | 2 | Index of the row whose register is written |
| cfg_data | input | 8 | New boundary value, 16 MB units |
| addr_valid | input | 1 | Address qualifier |
| addr | input | 31 | Physical address to decode |
| dec_valid | output | 1 | Decode result valid, one cycle after `addr_valid` |
| row_sel | output | 4 | One-hot row select |
| row_hit | output | 1 | Address falls in a non-empty row |
| row_miss | output | 1 | Address lies above every row |
| row_offset | output | 31 | Address relative to the base of the selected row |

## Verification
The hardest case to reach is a boundary table that is not monotonic: a limit that falls below a lower row's limit, followed by a row that rises again. Only there can the running base differ from the previous register value. The stimulus table loads such tables directly, for example limits 4, 2, 6, 6. It then probes addresses just inside and just past the base that the skipped row leaves behind. A second hard-to-reach case is a register write in the same cycle as an address. A directed test issues both in one cycle and then repeats the address, which shows whether the old or the new limit was used.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int unsigned RBD_NUM_ROWS = 4;
  localparam int unsigned RBD_LIM_W    = 8;
  localparam int unsigned RBD_ADDR_W   = 31;
  localparam int unsigned RBD_UNIT_LSB = 24;
endpackage

// File: rtl/rbd_limit_regs.sv
module rbd_limit_regs #(
  parameter int unsigned NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int unsigned LIM_W    = rbd_pkg::RBD_LIM_W,
  localparam int unsigned IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [LIM_W-1:0]                 wr_data,
  output logic [NUM_ROWS-1:0][LIM_W-1:0]   lim_o
);
  logic [NUM_ROWS-1:0][LIM_W-1:0] lim_q, lim_d;
  logic [NUM_ROWS-1:0]            lim_en;

  always_comb begin
    for (int i = 0; i < NUM_ROWS; i++) begin
      lim_en[i] = wr_en && (wr_idx == IDX_W'(i));
      lim_d[i]  = wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lim_q[g] <= '0;
        else if (lim_en[g])  lim_q[g] <= lim_d[g];
      end
    end
  endgenerate

  assign lim_o = lim_q;

  // R2: a write lands in the addressed register on the next edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lim_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rbd_bound_chain.sv
module rbd_bound_chain #(
  parameter int unsigned NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int unsigned LIM_W    = rbd_pkg::RBD_LIM_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_ROWS-1:0][LIM_W-1:0]   lim_i,
  output logic [NUM_ROWS-1:0][LIM_W-1:0]   base_o,
  output logic [NUM_ROWS-1:0]              live_o
);
  // running maximum of lower limits gives each row its base
  generate
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_base
      if (g == 0) begin : g_first
        assign base_o[g] = '0;
      end else begin : g_rest
        assign base_o[g] = (lim_i[g-1] > base_o[g-1]) ? lim_i[g-1] : base_o[g-1];
      end
      assign live_o[g] = lim_i[g] > base_o[g];
    end
  endgenerate

  generate
    for (genvar g = 1; g < NUM_ROWS; g++) begin : g_chk
      // R4 / R6: bases never fall, even when a limit does
      assert_base_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        base_o[g] >= base_o[g-1] && base_o[g] >= lim_i[g-1]);
    end
  endgenerate
endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
  parameter int unsigned NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int unsigned LIM_W    = rbd_pkg::RBD_LIM_W,
  parameter int unsigned HI_W     = rbd_pkg::RBD_ADDR_W - rbd_pkg::RBD_UNIT_LSB
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [HI_W-1:0]                  addr_hi,
  input  logic [NUM_ROWS-1:0][LIM_W-1:0]   lim_i,
  input  logic [NUM_ROWS-1:0][LIM_W-1:0]   base_i,
  input  logic [NUM_ROWS-1:0]              live_i,
  output logic [NUM_ROWS-1:0]              sel_o,
  output logic [LIM_W-1:0]                 base_sel_o
);
  logic [LIM_W-1:0]    hi_w;
  logic [NUM_ROWS-1:0] raw, blocked;

  assign hi_w = LIM_W'(addr_hi);

  generate
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
      assign raw[g] = live_i[g] && (hi_w >= base_i[g]) && (hi_w < lim_i[g]);
      if (g == 0) begin : g_p0
        assign blocked[g] = 1'b0;
      end else begin : g_pn
        assign blocked[g] = blocked[g-1] | raw[g-1];
      end
    end
  endgenerate

  assign sel_o = raw & ~blocked;

  always_comb begin
    base_sel_o = '0;
    for (int i = 0; i < NUM_ROWS; i++)
      base_sel_o = base_sel_o | (base_i[i] & {LIM_W{sel_o[i]}});
  end

  // R6: ranges never overlap, so raw compares are already exclusive
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(raw));
  // R5: an empty row never matches
  assert_empty_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o & ~live_i) == '0);
endmodule

// File: rtl/rbd_row_decoder.sv
module rbd_row_decoder #(
  parameter int unsigned NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int unsigned LIM_W    = rbd_pkg::RBD_LIM_W,
  parameter int unsigned ADDR_W   = rbd_pkg::RBD_ADDR_W,
  parameter int unsigned UNIT_LSB = rbd_pkg::RBD_UNIT_LSB,
  localparam int unsigned IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned HI_W    = ADDR_W - UNIT_LSB,
  localparam int unsigned SPAN_W  = LIM_W + UNIT_LSB,
  localparam int unsigned CMP_W   = (SPAN_W > ADDR_W) ? SPAN_W : ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [LIM_W-1:0]    cfg_data,
  input  logic                addr_valid,
  input  logic [ADDR_W-1:0]   addr,
  output logic                dec_valid,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                row_hit,
  output logic                row_miss,
  output logic [ADDR_W-1:0]   row_offset
);
  // reset: asserted at once, released on the clock
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic [NUM_ROWS-1:0][LIM_W-1:0] lim, base;
  logic [NUM_ROWS-1:0]            live, sel_c;
  logic [LIM_W-1:0]               base_sel;

  rbd_limit_regs #(.NUM_ROWS(NUM_ROWS), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(cfg_data), .lim_o(lim));

  rbd_bound_chain #(.NUM_ROWS(NUM_ROWS), .LIM_W(LIM_W)) u_chain (
    .clk(clk), .rst_n(rst_ns), .lim_i(lim), .base_o(base), .live_o(live));

  rbd_row_match #(.NUM_ROWS(NUM_ROWS), .LIM_W(LIM_W), .HI_W(HI_W)) u_match (
    .clk(clk), .rst_n(rst_ns), .addr_hi(addr[ADDR_W-1:UNIT_LSB]),
    .lim_i(lim), .base_i(base), .live_i(live),
    .sel_o(sel_c), .base_sel_o(base_sel));

  // next-state
  logic                hit_c;
  logic [CMP_W-1:0]    diff_c;
  logic [ADDR_W-1:0]   off_d;

  always_comb begin
    hit_c  = |sel_c;
    diff_c = CMP_W'(addr) - CMP_W'({base_sel, {UNIT_LSB{1'b0}}});
    off_d  = hit_c ? diff_c[ADDR_W-1:0] : '0;
  end

  // registers
  logic                vld_q, hit_q, miss_q;
  logic [NUM_ROWS-1:0] sel_q;
  logic [ADDR_W-1:0]   off_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) vld_q <= 1'b0;
    else         vld_q <= addr_valid;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sel_q  <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      off_q  <= '0;
    end else if (addr_valid) begin
      sel_q  <= sel_c;
      hit_q  <= hit_c;
      miss_q <= ~hit_c;
      off_q  <= off_d;
    end
  end

  assign dec_valid  = vld_q;
  assign row_sel    = sel_q;
  assign row_hit    = hit_q;
  assign row_miss   = miss_q;
  assign row_offset = off_q;

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(row_sel) && (row_hit == (row_sel != '0)));
  assert_hit_xor_miss_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    dec_valid |-> (row_hit != row_miss));
  assert_miss_zero_offset_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    row_miss |-> (row_offset == '0 && row_sel == '0));
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    dec_valid == $past(addr_valid));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !addr_valid |=> $stable(row_sel) && $stable(row_offset));
endmodule

// File: tb/rbd_row_decoder_test.sv
`timescale 1ns/1ps
module rbd_row_decoder_test;
  typedef struct packed {
    logic [31:0] regs;   // {row3,row2,row1,row0}
    logic [30:0] addr;
    logic [3:0]  sel;
    logic        miss;
    logic [30:0] off;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [0:NV-1] = '{
    '{32'h04030201, 31'h00000000, 4'b0001, 1'b0, 31'h00000000}, // R3 bottom of row 0
    '{32'h04030201, 31'h00FFFFFF, 4'b0001, 1'b0, 31'h00FFFFFF}, // R3 top byte of row 0
    '{32'h04030201, 31'h01000000, 4'b0010, 1'b0, 31'h00000000}, // R4 at limit -> next row
    '{32'h04030201, 31'h03123456, 4'b1000, 1'b0, 31'h00123456}, // R4 R8 row 3
    '{32'h04030201, 31'h04000000, 4'b0000, 1'b1, 31'h00000000}, // R7 at top limit
    '{32'h02030101, 31'h01000000, 4'b0100, 1'b0, 31'h00000000}, // R5 row 1 empty
    '{32'h02030101, 31'h02800000, 4'b0100, 1'b0, 31'h01800000}, // R5 R8
    '{32'h02030101, 31'h03000000, 4'b0000, 1'b1, 31'h00000000}, // R6 R7 falling row 3
    '{32'h06060204, 31'h03000000, 4'b0001, 1'b0, 31'h03000000}, // R6 row 0 wide
    '{32'h06060204, 31'h05000000, 4'b0100, 1'b0, 31'h01000000}, // R6 base stays 4
    '{32'h06060204, 31'h06000000, 4'b0000, 1'b1, 31'h00000000}, // R5 R7
    '{32'h80000000, 31'h7FFFFFFF, 4'b1000, 1'b0, 31'h7FFFFFFF}, // R11 R5 only row 3
    '{32'hFF7F2010, 31'h7F000000, 4'b1000, 1'b0, 31'h00000000}, // R11 R4
    '{32'hFF7F2010, 31'h1FFFFFFF, 4'b0010, 1'b0, 31'h0FFFFFFF}, // R4 R8
    '{32'h00000000, 31'h00000000, 4'b0000, 1'b1, 31'h00000000}  // R7 all empty
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_data = '0;
  logic        addr_valid = 1'b0;
  logic [30:0] addr = '0;
  logic        dec_valid, row_hit, row_miss;
  logic [3:0]  row_sel;
  logic [30:0] row_offset;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rbd_row_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .addr_valid(addr_valid), .addr(addr),
    .dec_valid(dec_valid), .row_sel(row_sel), .row_hit(row_hit),
    .row_miss(row_miss), .row_offset(row_offset));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] val);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] regs);
    for (int r = 0; r < 4; r++) wr(2'(r), regs[8*r +: 8]);
  endtask

  task automatic present(input logic [30:0] a);
    addr_valid = 1'b1; addr = a;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dec_valid in reset", 64'(dec_valid), 64'd0);
    chk("R1 row_sel in reset", 64'(row_sel), 64'd0);
    chk("R1 hit/miss in reset", 64'({row_hit, row_miss}), 64'd0);
    chk("R1 offset in reset", 64'(row_offset), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    present(31'h00000000);
    chk("R1 miss after reset", 64'({row_sel, row_hit, row_miss}), 64'b0000_0_1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      load(VEC[v].regs);
      present(VEC[v].addr);
      chk("R9 dec_valid", 64'(dec_valid), 64'd1);
      chk("R4 row_sel", 64'(row_sel), 64'(VEC[v].sel));
      chk("R7 row_miss", 64'(row_miss), 64'(VEC[v].miss));
      chk("R10 row_hit", 64'(row_hit), 64'(VEC[v].sel != 4'b0000));
      chk("R8 row_offset", 64'(row_offset), 64'(VEC[v].off));
    end

    // R2 write in the same cycle as an address uses the old limit
    load(32'h04030201);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_data = 8'h02;
    addr_valid = 1'b1; addr = 31'h01000000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R2 same-cycle write uses old limit", 64'(row_sel), 64'b0010);
    @(negedge clk);
    addr_valid = 1'b0;
    chk("R2 later address uses new limit", 64'(row_sel), 64'b0001);
    chk("R2 offset with new limit", 64'(row_offset), 64'h01000000);

    // R9 outputs hold while addr_valid is low
    addr = 31'h03000000;
    @(negedge clk);
    chk("R9 dec_valid low", 64'(dec_valid), 64'd0);
    chk("R9 row_sel held", 64'(row_sel), 64'b0001);
    chk("R9 offset held", 64'(row_offset), 64'h01000000);

    // R1 reset mid-run clears the limits
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 row_sel cleared", 64'(row_sel), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    present(31'h00000000);
    chk("R1 limits cleared -> miss", 64'({row_hit, row_miss}), 64'b01);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule